// File: doc/BRIEF.md
# Beam-Timed NMI and Timer IRQ Controller

This block raises the non-maskable and maskable interrupt requests for a 16-bit console CPU. Its inputs are pulses from the video beam logic, the running horizontal cycle count and a few control bits. When vertical blanking begins, it sets a readable status byte. If the NMI enable bit is on, it also arms an NMI. That NMI is not taken at once: it is taken when the horizontal count reaches a fixed cycle on the following line. An instruction that rewrites the interrupt flags on its last cycle can also request an NMI, which fires a fixed number of cycles after that moment.

A timer position, loaded from outside, raises a level IRQ when the cycle count reaches it. The CPU services that IRQ only while its interrupt-disable flag is clear. At each line wrap the counter that drives the block is rebased to zero. The block rebases every live trigger position by the same line length, and leaves inactive positions (all-ones sentinels) as they are. A CPU halted in a wait-for-interrupt state is woken by either request, even a masked IRQ. The wake strobe carries the extra cycle cost that the wake adds.

Top module: `nmiirq_top`

## Requirements
- R1: After reset, statusOut equals the revision number REV (default 2) with bit 7 clear, irqLine is 0, and no take or wake strobe is active.
- R2: One clock after vblankStart, statusOut is 0x80 | REV. One clock after frameStart (and no vblankStart), it is REV.
- R3: While statusRead is high, statusOut shows the held value. One clock later, bit 7 is clear and the other bits are unchanged.
- R4: vblankStart with intEnable bit 7 set arms an NMI at horizontal cycle 12. nmiTake is high in a cycle exactly when an NMI is armed and hCycle >= 12. With bit 7 clear, no NMI is armed.
- R5: nmiTake lasts one cycle per armed NMI. Its position then becomes inactive until the NMI is armed again.
- R6: On lineWrap, an armed NMI position is reduced by lineLen, with the result clamped at 0. A timer position that is not the sentinel 0x0FFFFFFF is reduced by lineLen in the same way.
- R7: flagNmi arms an NMI whose position is hCycle + 6, taken from the cycle of the request.
- R8: The clock edge at which a loaded timer position is <= hCycle sets irqLine, and the timer position becomes inactive. irqLine then stays high until irqClear.
- R9: irqTake is high only when irqLine is high and irqDisable is low.
- R10: wakePulse is high when waiting is high and either nmiTake or irqLine is high, whatever irqDisable is. wakeCost is 14 (two 6-cycle CPU cycles plus half of a 4-cycle dot) with the pulse, and 0 otherwise.
- R11: When nmiTake is high, irqTake is low. A held IRQ is taken in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vblankStart | input | 1 | Pulse at the first blanking line |
| frameStart | input | 1 | Pulse at line 0 |
| lineWrap | input | 1 | Pulse when the cycle counter is rebased to a new line |
| lineLen | input | CYC_W | Amount subtracted at a line wrap |
| hCycle | input | CYC_W | Current horizontal cycle count |
| intEnable | input | 8 | Interrupt-enable register; bit 7 enables the blanking NMI |
| flagNmi | input | 1 | Last-cycle flag change requesting an NMI |
| timerLoad | input | 1 | Load timerPosIn as the next timer IRQ position |
| timerPosIn | input | TPOS_W | Next timer IRQ cycle |
| irqClear | input | 1 | Drop the IRQ line |
| irqDisable | input | 1 | CPU interrupt-disable flag |
| waiting | input | 1 | CPU halted waiting for an interrupt |
| statusRead | input | 1 | Read strobe of the status byte |
| nmiTake | output | 1 | NMI serviced this cycle |
| irqLine | output | 1 | Timer IRQ level |
| irqTake | output | 1 | IRQ serviced this cycle |
| statusOut | output | 8 | NMI status byte |
| wakePulse | output | 1 | Wake from the wait state |
| wakeCost | output | COST_W | Extra cycles charged by the wake |

## Verification
The hardest case to reach from the ports is an NMI that was armed on one line and must then survive a line wrap. The rebased position has to land on the correct cycle of the new line, including the case where the clamp drives it to zero. The bench arms the NMI through a flag change at cycle 100 and wraps with several line lengths, one of them larger than the position. It then sweeps the cycle count one step at a time and expects exactly one take at the computed cycle. A timer position loaded above one line length is swept in the same way. A collision between an NMI and a held IRQ is set up by timing a flag-change request against a timer load at position zero.

// File: rtl/nmiirq_pkg.sv
package nmiirq_pkg;

  // Strobes from the control block to the register datapath
  typedef struct packed {
    logic nmiTake;      // clear pending NMI, park position
    logic nmiArmVblank; // arm NMI at the fixed blanking position
    logic nmiArmFlag;   // arm NMI relative to the current cycle
    logic rebase;       // line wrap: shift live positions down
    logic irqFire;      // timer reached: raise line, park position
    logic irqDrop;      // lower the IRQ line
    logic timerLoad;    // take a new timer position
    logic statusVblank; // status to blanking value
    logic statusFrame;  // status back to revision only
    logic statusClear;  // clear status bit 7 after a read
  } ctlStrobes_t;

endpackage

// File: rtl/nmiirq_ctrl.sv
module nmiirq_ctrl
  import nmiirq_pkg::*;
#(
  parameter int CYC_W      = 16,
  parameter int TPOS_W     = 28,
  parameter int NMI_EN_BIT = 7,
  parameter int CPU_CYC    = 6,
  parameter int DOT_CYC    = 4,
  parameter int COST_W     = 8
) (
  input  logic              vblankStart,
  input  logic              frameStart,
  input  logic              lineWrap,
  input  logic [CYC_W-1:0]  hCycle,
  input  logic [7:0]        intEnable,
  input  logic              flagNmi,
  input  logic              timerLoad,
  input  logic              irqClear,
  input  logic              irqDisable,
  input  logic              waiting,
  input  logic              statusRead,
  input  logic              nmiPending,
  input  logic [CYC_W-1:0]  nmiPos,
  input  logic [TPOS_W-1:0] timerPos,
  input  logic              irqLineQ,
  output ctlStrobes_t       strb,
  output logic              nmiTake,
  output logic              irqTake,
  output logic              wakePulse,
  output logic [COST_W-1:0] wakeCost
);

  localparam logic [TPOS_W-1:0] TIMER_OFF = {TPOS_W{1'b1}};
  localparam int WAKE_COST = 2 * CPU_CYC + DOT_CYC / 2;

  logic nmiDue;
  logic timerDue;

  always_comb begin
    nmiDue   = nmiPending && (hCycle >= nmiPos);
    timerDue = (timerPos != TIMER_OFF) && (TPOS_W'(hCycle) >= timerPos);
  end

  always_comb begin
    strb              = '0;
    strb.nmiTake      = nmiDue;
    strb.nmiArmVblank = vblankStart && intEnable[NMI_EN_BIT];
    strb.nmiArmFlag   = flagNmi;
    strb.rebase       = lineWrap;
    strb.irqFire      = timerDue;
    strb.irqDrop      = irqClear;
    strb.timerLoad    = timerLoad;
    strb.statusVblank = vblankStart;
    strb.statusFrame  = frameStart;
    strb.statusClear  = statusRead;
  end

  // NMI wins over IRQ in the same cycle; masked IRQ still wakes
  always_comb begin
    nmiTake   = nmiDue;
    irqTake   = irqLineQ && !irqDisable && !nmiDue;
    wakePulse = waiting && (nmiDue || irqLineQ);
    wakeCost  = wakePulse ? COST_W'(WAKE_COST) : '0;
  end

endmodule

// File: rtl/nmiirq_dpath.sv
module nmiirq_dpath
  import nmiirq_pkg::*;
#(
  parameter int CYC_W      = 16,
  parameter int TPOS_W     = 28,
  parameter int REV        = 2,
  parameter int NMI_HPOS   = 12,
  parameter int FLAG_DELAY = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [CYC_W-1:0]  hCycle,
  input  logic [CYC_W-1:0]  lineLen,
  input  logic [TPOS_W-1:0] timerPosIn,
  output logic              nmiPending,
  output logic [CYC_W-1:0]  nmiPos,
  output logic [TPOS_W-1:0] timerPos,
  output logic              irqLineQ,
  output logic [7:0]        status
);

  localparam logic [CYC_W-1:0]  NMI_OFF    = {CYC_W{1'b1}};
  localparam logic [TPOS_W-1:0] TIMER_OFF  = {TPOS_W{1'b1}};
  localparam logic [7:0]        STAT_IDLE  = 8'(REV) & 8'h7F;
  localparam logic [7:0]        STAT_BLANK = STAT_IDLE | 8'h80;

  logic [CYC_W-1:0]  nmiShifted;
  logic [TPOS_W-1:0] lenWide;
  logic [TPOS_W-1:0] timerShifted;

  always_comb begin
    lenWide      = TPOS_W'(lineLen);
    nmiShifted   = (nmiPos > lineLen) ? (nmiPos - lineLen) : '0;
    timerShifted = (timerPos > lenWide) ? (timerPos - lenWide) : '0;
  end

  // NMI pending flag and trigger position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPending <= 1'b0;
      nmiPos     <= NMI_OFF;
    end else begin
      if (strb.nmiArmFlag) begin
        nmiPending <= 1'b1;
        nmiPos     <= hCycle + CYC_W'(FLAG_DELAY);
      end else if (strb.nmiArmVblank) begin
        nmiPending <= 1'b1;
        nmiPos     <= CYC_W'(NMI_HPOS);
      end else if (strb.nmiTake) begin
        nmiPending <= 1'b0;
        nmiPos     <= NMI_OFF;
      end else if (strb.rebase && (nmiPos != NMI_OFF)) begin
        nmiPos <= nmiShifted;
      end
    end
  end

  // Timer position and IRQ level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerPos <= TIMER_OFF;
      irqLineQ <= 1'b0;
    end else begin
      if (strb.timerLoad) begin
        timerPos <= timerPosIn;
      end else if (strb.irqFire) begin
        timerPos <= TIMER_OFF;
      end else if (strb.rebase && (timerPos != TIMER_OFF)) begin
        timerPos <= timerShifted;
      end
      if (strb.irqFire) begin
        irqLineQ <= 1'b1;
      end else if (strb.irqDrop) begin
        irqLineQ <= 1'b0;
      end
    end
  end

  // Status byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= STAT_IDLE;
    end else if (strb.statusVblank) begin
      status <= STAT_BLANK;
    end else if (strb.statusFrame) begin
      status <= STAT_IDLE;
    end else if (strb.statusClear) begin
      status <= status & 8'h7F;
    end
  end

endmodule

// File: rtl/nmiirq_top.sv
module nmiirq_top
  import nmiirq_pkg::*;
#(
  parameter int CYC_W      = 16,
  parameter int TPOS_W     = 28,
  parameter int REV        = 2,
  parameter int NMI_HPOS   = 12,
  parameter int FLAG_DELAY = 6,
  parameter int NMI_EN_BIT = 7,
  parameter int CPU_CYC    = 6,
  parameter int DOT_CYC    = 4,
  parameter int COST_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankStart,
  input  logic              frameStart,
  input  logic              lineWrap,
  input  logic [CYC_W-1:0]  lineLen,
  input  logic [CYC_W-1:0]  hCycle,
  input  logic [7:0]        intEnable,
  input  logic              flagNmi,
  input  logic              timerLoad,
  input  logic [TPOS_W-1:0] timerPosIn,
  input  logic              irqClear,
  input  logic              irqDisable,
  input  logic              waiting,
  input  logic              statusRead,
  output logic              nmiTake,
  output logic              irqLine,
  output logic              irqTake,
  output logic [7:0]        statusOut,
  output logic              wakePulse,
  output logic [COST_W-1:0] wakeCost
);

  ctlStrobes_t       strb;
  logic              nmiPending;
  logic [CYC_W-1:0]  nmiPos;
  logic [TPOS_W-1:0] timerPos;
  logic              irqLineQ;
  logic [7:0]        status;

  nmiirq_ctrl #(
    .CYC_W(CYC_W), .TPOS_W(TPOS_W), .NMI_EN_BIT(NMI_EN_BIT),
    .CPU_CYC(CPU_CYC), .DOT_CYC(DOT_CYC), .COST_W(COST_W)
  ) u_ctrl (
    .vblankStart(vblankStart), .frameStart(frameStart), .lineWrap(lineWrap),
    .hCycle(hCycle), .intEnable(intEnable), .flagNmi(flagNmi),
    .timerLoad(timerLoad), .irqClear(irqClear), .irqDisable(irqDisable),
    .waiting(waiting), .statusRead(statusRead), .nmiPending(nmiPending),
    .nmiPos(nmiPos), .timerPos(timerPos), .irqLineQ(irqLineQ),
    .strb(strb), .nmiTake(nmiTake), .irqTake(irqTake),
    .wakePulse(wakePulse), .wakeCost(wakeCost)
  );

  nmiirq_dpath #(
    .CYC_W(CYC_W), .TPOS_W(TPOS_W), .REV(REV),
    .NMI_HPOS(NMI_HPOS), .FLAG_DELAY(FLAG_DELAY)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hCycle(hCycle),
    .lineLen(lineLen), .timerPosIn(timerPosIn), .nmiPending(nmiPending),
    .nmiPos(nmiPos), .timerPos(timerPos), .irqLineQ(irqLineQ),
    .status(status)
  );

  assign irqLine   = irqLineQ;
  assign statusOut = status;

endmodule

// File: rtl/nmiirq_chk.sv
module nmiirq_chk #(
  parameter int COST_W   = 8,
  parameter int EXP_COST = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              vblankStart,
  input logic              frameStart,
  input logic              flagNmi,
  input logic              irqClear,
  input logic              irqDisable,
  input logic              waiting,
  input logic              statusRead,
  input logic              nmiTake,
  input logic              irqLine,
  input logic              irqTake,
  input logic [7:0]        statusOut,
  input logic              wakePulse,
  input logic [COST_W-1:0] wakeCost
);

  AST_NMI_OVER_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    nmiTake |-> !irqTake); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (irqDisable || !irqLine) |-> !irqTake); // R9
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (nmiTake && !vblankStart && !flagNmi) |=> !nmiTake); // R5
  AST_BLANK_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart |=> statusOut[7]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !vblankStart) |=> !statusOut[7]); // R3
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (irqLine && !irqClear) |=> irqLine); // R8
  AST_WAKE_COST: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (waiting && wakeCost == COST_W'(EXP_COST))); // R10

endmodule

bind nmiirq_top nmiirq_chk #(.COST_W(COST_W)) u_chk (
  .clk(clk), .rstN(rstN), .vblankStart(vblankStart), .frameStart(frameStart),
  .flagNmi(flagNmi), .irqClear(irqClear), .irqDisable(irqDisable),
  .waiting(waiting), .statusRead(statusRead), .nmiTake(nmiTake),
  .irqLine(irqLine), .irqTake(irqTake), .statusOut(statusOut),
  .wakePulse(wakePulse), .wakeCost(wakeCost)
);

// File: tb/sim_nmiirq_top.sv
`timescale 1ns/1ps
module sim_nmiirq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vblankStart = 1'b0, frameStart = 1'b0, lineWrap = 1'b0;
  logic [15:0] lineLen = '0, hCycle = '0;
  logic [7:0]  intEnable = '0;
  logic        flagNmi = 1'b0, timerLoad = 1'b0;
  logic [27:0] timerPosIn = '0;
  logic        irqClear = 1'b0, irqDisable = 1'b1, waiting = 1'b0, statusRead = 1'b0;
  logic        nmiTake, irqLine, irqTake, wakePulse;
  logic [7:0]  statusOut, wakeCost;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nmiirq_top u0 (
    .clk(clk), .rstN(rstN), .vblankStart(vblankStart), .frameStart(frameStart),
    .lineWrap(lineWrap), .lineLen(lineLen), .hCycle(hCycle), .intEnable(intEnable),
    .flagNmi(flagNmi), .timerLoad(timerLoad), .timerPosIn(timerPosIn),
    .irqClear(irqClear), .irqDisable(irqDisable), .waiting(waiting),
    .statusRead(statusRead), .nmiTake(nmiTake), .irqLine(irqLine),
    .irqTake(irqTake), .statusOut(statusOut), .wakePulse(wakePulse),
    .wakeCost(wakeCost)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finishRun();
  end

  initial begin
    int bases[4] = '{0, 5, 30, 100};
    int lens[3]  = '{50, 100, 120};
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    // R1 reset state
    chkVal("R1 status", 32'(statusOut), 32'h02);
    chkBit("R1 irqLine", irqLine, 1'b0);
    chkBit("R1 nmiTake", nmiTake, 1'b0);
    chkBit("R1 wakePulse", wakePulse, 1'b0);
    tick();

    // R2 / R4 / R5: blanking NMI at cycle 12
    intEnable = 8'h80; vblankStart = 1'b1; hCycle = 16'd0;
    tick();
    vblankStart = 1'b0;
    #1 chkVal("R2 blank status", 32'(statusOut), 32'h82);
    for (int h = 0; h <= 20; h++) begin
      hCycle = 16'(h);
      #1 chkBit("R4 R5 nmi at 12", nmiTake, h == 12);
      tick();
    end

    // R3 read returns held value, then clears bit 7
    statusRead = 1'b1;
    #1 chkVal("R3 read value", 32'(statusOut), 32'h82);
    tick();
    statusRead = 1'b0;
    #1 chkVal("R3 cleared", 32'(statusOut), 32'h02);

    // R4 enable clear: no NMI; R2 frame start
    intEnable = 8'h00; vblankStart = 1'b1; hCycle = 16'd0;
    tick();
    vblankStart = 1'b0;
    for (int h = 0; h <= 40; h++) begin
      hCycle = 16'(h);
      #1 chkBit("R4 disabled", nmiTake, 1'b0);
      tick();
    end
    chkVal("R2 blank again", 32'(statusOut), 32'h82);
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
    #1 chkVal("R2 frame status", 32'(statusOut), 32'h02);

    // R7 flag-change NMI six cycles later
    foreach (bases[i]) begin
      hCycle = 16'(bases[i]); flagNmi = 1'b1;
      tick();
      flagNmi = 1'b0;
      for (int k = 0; k <= 8; k++) begin
        hCycle = 16'(bases[i] + k);
        #1 chkBit("R7 flag nmi", nmiTake, k == 6);
        tick();
      end
    end

    // R6 NMI position rebased at line wrap, clamped at 0
    foreach (lens[i]) begin
      int expPos;
      expPos = (106 > lens[i]) ? 106 - lens[i] : 0;
      hCycle = 16'd100; flagNmi = 1'b1;
      tick();
      flagNmi = 1'b0; lineWrap = 1'b1; lineLen = 16'(lens[i]); hCycle = 16'd0;
      #1 chkBit("R6 no early take", nmiTake, 1'b0);
      tick();
      lineWrap = 1'b0;
      for (int h = 0; h <= 60; h++) begin
        hCycle = 16'(h);
        #1 chkBit("R6 rebased nmi", nmiTake, h == expPos);
        tick();
      end
    end

    // R8 / R9 timer IRQ while masked
    irqDisable = 1'b1; timerPosIn = 28'd30; timerLoad = 1'b1; hCycle = 16'd0;
    tick();
    timerLoad = 1'b0;
    for (int h = 0; h <= 35; h++) begin
      hCycle = 16'(h);
      #1 chkBit("R8 irq level", irqLine, h >= 31);
      chkBit("R9 masked", irqTake, 1'b0);
      tick();
    end
    // R10 wake with masked IRQ
    waiting = 1'b1;
    #1 chkBit("R10 wake irq", wakePulse, 1'b1);
    chkVal("R10 cost", 32'(wakeCost), 32'd14);
    waiting = 1'b0;
    #1 chkBit("R10 no wait", wakePulse, 1'b0);
    chkVal("R10 cost idle", 32'(wakeCost), 32'd0);
    irqDisable = 1'b0;
    #1 chkBit("R9 unmasked take", irqTake, 1'b1);
    irqClear = 1'b1;
    tick();
    irqClear = 1'b0; irqDisable = 1'b1;
    #1 chkBit("R8 cleared", irqLine, 1'b0);

    // R6 timer rebase
    timerPosIn = 28'd130; timerLoad = 1'b1; hCycle = 16'd0;
    tick();
    timerLoad = 1'b0; lineWrap = 1'b1; lineLen = 16'd100;
    tick();
    lineWrap = 1'b0;
    for (int h = 0; h <= 35; h++) begin
      hCycle = 16'(h);
      #1 chkBit("R6 R8 rebased timer", irqLine, h >= 31);
      tick();
    end
    irqClear = 1'b1;
    tick();
    irqClear = 1'b0;

    // R10 wake by NMI
    waiting = 1'b1; hCycle = 16'd0; flagNmi = 1'b1;
    tick();
    flagNmi = 1'b0;
    for (int h = 0; h <= 7; h++) begin
      hCycle = 16'(h);
      #1 chkBit("R10 wake nmi", wakePulse, h == 6);
      tick();
    end
    waiting = 1'b0;

    // R11 NMI and IRQ eligible together
    irqDisable = 1'b0; timerPosIn = 28'd0; timerLoad = 1'b1; hCycle = 16'd0;
    tick();
    timerLoad = 1'b0; flagNmi = 1'b1;
    tick();
    flagNmi = 1'b0; hCycle = 16'd6;
    #1 chkBit("R11 nmi taken", nmiTake, 1'b1);
    chkBit("R11 irq held off", irqTake, 1'b0);
    tick();
    #1 chkBit("R11 irq after", irqTake, 1'b1);
    irqClear = 1'b1;
    tick();
    irqClear = 1'b0;

    finishRun();
  end

endmodule